// File: doc/BRIEF.md
# Upscaler Source Position Stepper

This block walks a fixed-point source position across the output raster of an upscaler. It keeps one accumulator for the horizontal axis and one for the vertical axis. For every accepted output pixel it offers the integer source column together with a 6-bit interpolation phase. For the current output line it offers the integer source row and its phase. Each step is the input-to-output resolution ratio as an unsigned value with 15 fraction bits, so 0x8000 is 1.0. Because the block only enlarges images, any step above 1.0 is limited to 1.0.

Timing comes from two control pulses and an active flag. `frame_start` rewinds both axes. `line_start` rewinds the horizontal axis and moves the vertical axis down one output line, except on the first line of a frame. While `disp_active` is high, positions leave on a valid/ready stream. The position on offer stays frozen for as long as the consumer holds `out_ready` low, and it advances only when a transfer completes. The block never stalls the timing pulses: a pulse takes effect in the cycle it arrives, whatever the state of the stream.

A small write port loads the two step values and an emulated panel line period. The line period is a 16-bit count of input clocks times 16. The block does not use it; it holds the value and presents it on an output.

Top module: `scan_pos_accum`

## Requirements
- R1: After reset both steps are 0x8000, `hper_emul` is 0x5400, and every position output is zero.
- R2: When `cfg_we` is high, `cfg_addr` selects the target: 0 is the horizontal step, 1 is the vertical step, 2 is the emulated line period. The new value is in use from the next clock edge. `hper_emul` shows the held period value.
- R3: A step value written above 0x8000 is stored as 0x8000. Per transfer the source column advances by at most one.
- R4: Each stream transfer (`out_valid` and `out_ready` both high) adds the horizontal step to the horizontal accumulator.
- R5: `out_valid` equals `disp_active` with both pulses low. While `out_valid` is high and `out_ready` is low, the horizontal outputs stay unchanged.
- R6: `line_start` clears the horizontal accumulator and takes priority over a pixel advance.
- R7: On `line_start`, the vertical step is added to the vertical accumulator, except on the first `line_start` at or after `frame_start`. At all other times the vertical outputs hold.
- R8: `frame_start` clears both accumulators and arms the first-line rule. If `line_start` arrives in the same cycle, that pulse counts as the first line.
- R9: Index outputs are the accumulator shifted right by 15 bits. Phase outputs are accumulator bits 14 down to 9. The horizontal accumulator is 27 bits wide and the vertical one is 26 bits wide, and both wrap.
- R10: A write with `cfg_addr` equal to 3 changes no held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration target select |
| cfg_wdata | input | 16 | Configuration write data |
| frame_start | input | 1 | Start-of-frame pulse |
| line_start | input | 1 | Start-of-output-line pulse |
| disp_active | input | 1 | Output pixels wanted on the stream |
| out_valid | output | 1 | A position is offered |
| out_ready | input | 1 | Consumer accepts the position |
| out_hidx | output | 12 | Source column index |
| out_hphase | output | 6 | Horizontal interpolation phase |
| out_vidx | output | 11 | Source row index |
| out_vphase | output | 6 | Vertical interpolation phase |
| hper_emul | output | 16 | Held emulated line period |

## Verification
The bench stalls the stream at random while pixels are active. A design that advanced on valid alone would run ahead of the consumer. The bench fires `line_start` during a live transfer, and `frame_start` together with `line_start`. These cases expose a design that lets the pixel add win over the clear, or that skips or doubles the first row step. It writes steps above 1.0 and to the unused address. A design without the limit would jump more than one column, and an address decode leak would corrupt a step or the line period. Steps with odd fraction bits check the phase slice: taking the wrong bits gives phases that drift away from the reference model.

// File: rtl/scan_pos_pkg.sv
package scan_pos_pkg;
  localparam int STEP_W  = 16;
  localparam int FRAC_W  = 15;
  localparam int PHASE_W = 6;
  localparam logic [STEP_W-1:0] UNITY = 16'h8000;

  typedef enum logic [1:0] {
    SEL_HSTEP = 2'd0,
    SEL_VSTEP = 2'd1,
    SEL_HPER  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  function automatic logic [STEP_W-1:0] cap_step(input logic [STEP_W-1:0] v);
    return (v > UNITY) ? UNITY : v;
  endfunction
endpackage

// File: rtl/scan_pos_cfg.sv
module scan_pos_cfg
  import scan_pos_pkg::*;
#(
  parameter logic [STEP_W-1:0] HPER_RST = 16'h5400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [STEP_W-1:0] wdata,
  output logic [STEP_W-1:0] hstep,
  output logic [STEP_W-1:0] vstep,
  output logic [STEP_W-1:0] hper
);
  localparam int NRATIO = 2;
  logic [STEP_W-1:0] ratio_q [NRATIO];

  for (genvar g = 0; g < NRATIO; g++) begin : g_ratio
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ratio_q[g] <= UNITY;
      end else if (we && (addr == 2'(g))) begin
        ratio_q[g] <= cap_step(wdata);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hper <= HPER_RST;
    end else if (we && (cfg_sel_e'(addr) == SEL_HPER)) begin
      hper <= wdata;
    end
  end

  assign hstep = ratio_q[SEL_HSTEP];
  assign vstep = ratio_q[SEL_VSTEP];
endmodule

// File: rtl/scan_pos_axis.sv
module scan_pos_axis
  import scan_pos_pkg::*;
#(
  parameter int IDX_W = 12,
  localparam int ACC_W = IDX_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               add,
  input  logic [STEP_W-1:0]  step,
  output logic [IDX_W-1:0]   idx,
  output logic [PHASE_W-1:0] phase
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr) begin
      acc_q <= '0;
    end else if (add) begin
      acc_q <= acc_q + ACC_W'(step);
    end
  end

  assign idx   = acc_q[ACC_W-1:FRAC_W];
  assign phase = acc_q[FRAC_W-1 -: PHASE_W];
endmodule

// File: rtl/scan_pos_accum.sv
module scan_pos_accum
  import scan_pos_pkg::*;
#(
  parameter int HIDX_W = 12,
  parameter int VIDX_W = 11,
  parameter logic [15:0] HPER_RST = 16'h5400
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [15:0]        cfg_wdata,
  input  logic               frame_start,
  input  logic               line_start,
  input  logic               disp_active,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [HIDX_W-1:0]  out_hidx,
  output logic [PHASE_W-1:0] out_hphase,
  output logic [VIDX_W-1:0]  out_vidx,
  output logic [PHASE_W-1:0] out_vphase,
  output logic [15:0]        hper_emul
);
  logic [STEP_W-1:0] hstep, vstep;
  logic first_line_q;
  logic xfer, row_add;

  scan_pos_cfg #(.HPER_RST(HPER_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .hstep(hstep), .vstep(vstep), .hper(hper_emul)
  );

  assign out_valid = disp_active && !line_start && !frame_start;
  assign xfer      = out_valid && out_ready;
  assign row_add   = line_start && !frame_start && !first_line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_line_q <= 1'b0;
    end else if (frame_start) begin
      first_line_q <= !line_start;
    end else if (line_start) begin
      first_line_q <= 1'b0;
    end
  end

  scan_pos_axis #(.IDX_W(HIDX_W)) u_hax (
    .clk(clk), .rst_n(rst_n), .clr(frame_start || line_start), .add(xfer),
    .step(hstep), .idx(out_hidx), .phase(out_hphase)
  );

  scan_pos_axis #(.IDX_W(VIDX_W)) u_vax (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .add(row_add),
    .step(vstep), .idx(out_vidx), .phase(out_vphase)
  );
endmodule

// File: rtl/scan_pos_accum_chk.sv
module scan_pos_accum_chk #(
  parameter int HIDX_W = 12,
  parameter int VIDX_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_start,
  input logic              out_valid,
  input logic              out_ready,
  input logic [HIDX_W-1:0] out_hidx,
  input logic [5:0]        out_hphase,
  input logic [VIDX_W-1:0] out_vidx,
  input logic [5:0]        out_vphase
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable({out_hidx, out_hphase})); // R5
  AST_PULSE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start || frame_start) |-> !out_valid); // R5
  AST_LINE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (out_hidx == '0 && out_hphase == '0)); // R6
  AST_FRAME_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (out_vidx == '0 && out_vphase == '0 && out_hidx == '0)); // R8
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !frame_start) |=> $stable({out_vidx, out_vphase})); // R7
  AST_COL_STEP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (HIDX_W'(out_hidx - $past(out_hidx)) <= HIDX_W'(1))); // R3
endmodule

bind scan_pos_accum scan_pos_accum_chk #(.HIDX_W(HIDX_W), .VIDX_W(VIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
  .out_valid(out_valid), .out_ready(out_ready), .out_hidx(out_hidx),
  .out_hphase(out_hphase), .out_vidx(out_vidx), .out_vphase(out_vphase)
);

// File: tb/scan_pos_accum_test.sv
module scan_pos_accum_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic frame_start = 1'b0, line_start = 1'b0, disp_active = 1'b0, out_ready = 1'b0;
  logic out_valid;
  logic [11:0] out_hidx;
  logic [5:0] out_hphase, out_vphase;
  logic [10:0] out_vidx;
  logic [15:0] hper_emul;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  longint m_hacc, m_vacc, m_hstep, m_vstep, m_hper;
  bit m_arm;

  always #2 clk = ~clk;

  scan_pos_accum uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .line_start(line_start), .disp_active(disp_active),
    .out_valid(out_valid), .out_ready(out_ready), .out_hidx(out_hidx),
    .out_hphase(out_hphase), .out_vidx(out_vidx), .out_vphase(out_vphase),
    .hper_emul(hper_emul)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint cap(input longint v);
    return (v > 32768) ? 32768 : v;
  endfunction

  task automatic compare_all();
    check("R5 valid", out_valid, disp_active && !line_start && !frame_start);
    check("R4/R9 hidx", out_hidx, (m_hacc >> 15) & 12'hFFF);
    check("R9 hphase", out_hphase, (m_hacc >> 9) & 63);
    check("R7/R9 vidx", out_vidx, (m_vacc >> 15) & 11'h7FF);
    check("R7/R9 vphase", out_vphase, (m_vacc >> 9) & 63);
    check("R2 hper", hper_emul, m_hper);
  endtask

  // Drive one cycle, advance the model, then compare after the edge.
  task automatic cyc(input bit we, input logic [1:0] a, input logic [15:0] d,
                     input bit fs, input bit ls, input bit act, input bit rdy);
    bit v;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    frame_start = fs; line_start = ls; disp_active = act; out_ready = rdy;
    v = act && !ls && !fs;
    if (fs) begin
      m_hacc = 0; m_vacc = 0; m_arm = !ls;
    end else if (ls) begin
      m_hacc = 0;
      if (m_arm) m_arm = 1'b0;
      else m_vacc = (m_vacc + m_vstep) & ((64'd1 << 26) - 1);
    end else if (v && rdy) begin
      m_hacc = (m_hacc + m_hstep) & ((64'd1 << 27) - 1);
    end
    if (we) begin
      case (a)
        2'd0: m_hstep = cap(d);
        2'd1: m_vstep = cap(d);
        2'd2: m_hper = d;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_line(input int n, input bit stall);
    cyc(0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 1, stall ? ($urandom_range(0, 2) != 0) : 1'b1);
  endtask

  initial begin
    m_hacc = 0; m_vacc = 0; m_hstep = 32768; m_vstep = 32768; m_hper = 16'h5400; m_arm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 hper reset", hper_emul, 16'h5400);
    check("R1 hidx reset", out_hidx, 0);
    check("R1 vidx reset", out_vidx, 0);
    check("R1 phase reset", {out_hphase, out_vphase}, 0);
    // R1: unity step after reset -> one column per transfer
    cyc(0, 0, 0, 1, 0, 0, 0);
    run_line(5, 0);
    check("R1 unity hidx", out_hidx, 5);
    // R2/R9: fractional steps
    cyc(1, 0, 16'h6000, 0, 0, 0, 0);
    cyc(1, 1, 16'h5556, 0, 0, 0, 0);
    cyc(1, 2, 16'h1234, 0, 0, 0, 0);
    check("R2 hper write", hper_emul, 16'h1234);
    run_line(3, 0);
    check("R9 hphase 3x0.75", out_hphase, 6'd16);
    check("R9 hidx 3x0.75", out_hidx, 2);
    // R5: stall holds position
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    check("R5 stall hidx", out_hidx, 2);
    // R6: line_start beats a pending transfer
    cyc(0, 0, 0, 0, 1, 1, 1);
    check("R6 clear over add", out_hidx, 0);
    // R3: step above unity is capped
    cyc(1, 0, 16'hC000, 0, 0, 0, 0);
    run_line(4, 0);
    check("R3 capped hidx", out_hidx, 4);
    check("R3 capped phase", out_hphase, 0);
    // R10: address 3 changes nothing
    cyc(1, 3, 16'h0001, 0, 0, 0, 0);
    run_line(2, 0);
    check("R10 hstep kept", out_hidx, 2);
    check("R10 hper kept", hper_emul, 16'h1234);
    // R8: frame_start with line_start together, then rows
    cyc(0, 0, 0, 1, 1, 0, 0);
    check("R8 frame clear", out_vidx, 0);
    run_line(1, 0);
    check("R7 second line adds", out_vphase, (16'h5556 >> 9) & 63);
    // R7: frame_start then separate first line_start does not add
    cyc(0, 0, 0, 1, 0, 0, 0);
    run_line(1, 0);
    check("R7 first line no add", out_vphase, 0);
    // Random mixture against the model
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) cyc(0, 0, 0, 1, $urandom_range(0, 1), 1, 1);
      else if (r < 8) cyc(0, 0, 0, 0, 1, $urandom_range(0, 1), 1);
      else if (r < 11) cyc(1, 2'($urandom_range(0, 3)), 16'($urandom_range(0, 65535)), 0, 0, 1, 1);
      else cyc(0, 0, 0, 0, 0, $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule